// File: doc/BRIEF.md
# Serial DAC Bank Update Sequencer

The block holds a 12-bit output code for each of 32 analog output channels and delivers them to eight serial DAC devices with four channels each. A host writes codes into a shadow register file over a valid/ready write channel. Each write names a channel and a code. A separate update request then sends every channel to its device, one 16-bit frame per channel. Each device has its own active-low chip select. After a device has received all four of its frames, a per-device load strobe makes those four outputs change together.

A mid-scale request, or the release of reset, presets every shadow register to code 0x800, which is 0 V in bipolar operation. It then sends that code to all channels. A mid-scale request takes priority over everything else. It cuts off any frame in progress and discards a write or update that arrives in the same cycle. The busy flag covers the whole transfer plus a settle window after the last load strobe, so the analog outputs have time to settle.

Back-pressure rule: `wr_ready` is high only while the block is idle. A write is taken on a rising clock edge where both `wr_valid` and `wr_ready` are high. The host must hold `wr_valid`, `wr_addr` and `wr_data` steady until that edge.

Top module: `dac_bank_seq`

## Requirements
- R1: When `rst_n` is released, `busy` is high and every shadow register holds 0x800. The block then sends 0x800 to all 32 channels and loads them with no host action.
- R2: Each frame has 16 bits and is sent MSB first. Bits [15:14] carry the channel within the device, bits [13:12] are 0, and bits [11:0] carry the code. `sdi` changes only while `sclk` is low and stays stable while `sclk` is high. The device samples on the rising edge of `sclk`.
- R3: Channel number n maps to device n/4 and device channel n%4; `wr_addr` uses the same numbering. An update sends device 0 to device 7 in order, and within each device sends channel 0 to channel 3 in order.
- R4: During a frame, only the `cs_n` bit of the addressed device is low. It stays low for exactly 16 rising `sclk` edges. `sclk` stays low whenever every `cs_n` bit is high.
- R5: After the fourth frame of a device, that device's `ldac_n` bit goes low for one half serial-clock period. During this pulse every `cs_n` bit is high.
- R6: `busy` rises on the clock edge that accepts an update or mid-scale request. It falls exactly SETTLE_CYCLES clock edges after the last load strobe ends.
- R7: `wr_ready` is high only when `busy` is low. A write that is held while `busy` is high is accepted once the block is idle, and it appears at the output only after a later update.
- R8: An update request that arrives while `busy` is high is ignored. When the current transfer ends, no further frames follow and `busy` stays low.
- R9: A mid-scale request in any state does the following: aborts a frame in progress, presets all shadow registers to 0x800 and restarts a full transfer. A write or update presented in the same cycle is discarded.
- R10: If an update request arrives in the same cycle as an accepted write, that update sends the newly written code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a mid-scale transfer on release |
| wr_valid | input | 1 | Host write request valid |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | 5 | Channel number 0..31 |
| wr_data | input | 12 | Output code |
| upd_req | input | 1 | One-cycle request to send all shadow codes |
| mid_req | input | 1 | One-cycle request to drive all outputs to mid-scale |
| busy | output | 1 | Transfer or settle window in progress |
| sclk | output | 1 | Shared serial clock, idle low |
| sdi | output | 1 | Shared serial data |
| cs_n | output | 8 | Per-device active-low chip select |
| ldac_n | output | 8 | Per-device active-low load strobe |

## Verification
Three functions can meet in a single cycle: the mid-scale preset, an accepted host write and the start of an update. The bench sets `wr_valid`, `upd_req` and `mid_req` together at one idle cycle. It expects the written channel to come back at 0x800 and the frames seen to be the mid-scale set only. A second collision fires the mid-scale request ten cycles into a frame for device 1. This must cut that frame short, and the bench then expects a clean full mid-scale transfer. The benign pairing of a write and an update in the same cycle is also checked: the new code must appear in that same update.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_FRAME,
    S_GAP,
    S_LOAD,
    S_SETTLE
  } seq_state_e;
endpackage

// File: rtl/dac_shadow_regs.sv
module dac_shadow_regs #(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 12,
  parameter int AW     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_load,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] regs [NUM_CH];

  // mid-scale preset outranks a host write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) regs[i] <= MID;
    end else if (mid_load) begin
      for (int i = 0; i < NUM_CH; i++) regs[i] <= MID;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata = regs[raddr];

  p_mid_preset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mid_load |=> (regs[0] == MID && regs[NUM_CH-1] == MID));
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int FRAME_W = 16,
  parameter int HALF    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic [FRAME_W-1:0] frame,
  output logic               active,
  output logic               sclk,
  output logic               sdi,
  output logic               done
);
  localparam int DIV_W = $clog2(HALF + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  logic               active_q, sclk_q, done_q;
  logic [DIV_W-1:0]   div_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        active_q <= 1'b0;
        sclk_q   <= 1'b0;
      end else if (start) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b0;
        div_q    <= '0;
        bit_q    <= '0;
        sh_q     <= frame;
      end else if (active_q) begin
        if (div_q == DIV_W'(HALF - 1)) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            // falling edge: advance to next bit or close the frame
            sclk_q <= 1'b0;
            if (bit_q == BIT_W'(FRAME_W - 1)) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign active = active_q;
  assign sclk   = sclk_q;
  assign sdi    = active_q & sh_q[FRAME_W-1];
  assign done   = done_q;

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (active && !sclk));
  p_sdi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdi));
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!active && !sclk));
endmodule

// File: rtl/dac_bank_seq.sv
module dac_bank_seq
  import dac_seq_pkg::*;
#(
  parameter int NUM_BANKS     = 8,
  parameter int CH_PER_BANK   = 4,
  parameter int DATA_W        = 12,
  parameter int FRAME_W       = 16,
  parameter int SCLK_HALF     = 2,
  parameter int SETTLE_CYCLES = 1000,
  parameter int CH_AW         = $clog2(NUM_BANKS * CH_PER_BANK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [CH_AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 upd_req,
  input  logic                 mid_req,
  output logic                 busy,
  output logic                 sclk,
  output logic                 sdi,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic [NUM_BANKS-1:0] ldac_n
);
  localparam int NUM_CH = NUM_BANKS * CH_PER_BANK;
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CSEL_W = (CH_PER_BANK > 1) ? $clog2(CH_PER_BANK) : 1;
  localparam int TMR_W  = $clog2(SETTLE_CYCLES + SCLK_HALF + 1);

  seq_state_e         state_q;
  logic [BANK_W-1:0]  bank_q;
  logic [CSEL_W-1:0]  ch_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [CH_AW-1:0]   rd_addr;
  logic [DATA_W-1:0]  rd_data;
  logic [FRAME_W-1:0] frame_w;
  logic               sh_active, sh_done, sh_start;

  assign wr_ready = (state_q == S_IDLE);
  assign busy     = (state_q != S_IDLE);
  assign rd_addr  = CH_AW'(bank_q) * CH_AW'(CH_PER_BANK) + CH_AW'(ch_q);
  assign sh_start = (state_q == S_START) && !mid_req;

  always_comb begin
    frame_w = '0;
    frame_w[FRAME_W-1 -: CSEL_W] = ch_q;
    frame_w[DATA_W-1:0] = rd_data;
  end

  dac_shadow_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .AW(CH_AW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .mid_load(mid_req),
    .we(wr_valid && wr_ready), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  dac_frame_shifter #(.FRAME_W(FRAME_W), .HALF(SCLK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .abort(mid_req),
    .frame(frame_w), .active(sh_active), .sclk(sclk), .sdi(sdi), .done(sh_done)
  );

  // reset releases into a mid-scale transfer (shadows already at mid)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_START;
      bank_q  <= '0;
      ch_q    <= '0;
      tmr_q   <= '0;
    end else if (mid_req) begin
      state_q <= S_START;
      bank_q  <= '0;
      ch_q    <= '0;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (upd_req) begin
          state_q <= S_START;
          bank_q  <= '0;
          ch_q    <= '0;
        end
        S_START: state_q <= S_FRAME;
        S_FRAME: if (sh_done) begin
          state_q <= S_GAP;
          tmr_q   <= '0;
        end
        S_GAP: if (tmr_q == TMR_W'(SCLK_HALF - 1)) begin
          tmr_q <= '0;
          if (ch_q == CSEL_W'(CH_PER_BANK - 1)) state_q <= S_LOAD;
          else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= S_START;
          end
        end else tmr_q <= tmr_q + 1'b1;
        S_LOAD: if (tmr_q == TMR_W'(SCLK_HALF - 1)) begin
          tmr_q <= '0;
          if (bank_q == BANK_W'(NUM_BANKS - 1)) state_q <= S_SETTLE;
          else begin
            bank_q  <= bank_q + 1'b1;
            ch_q    <= '0;
            state_q <= S_START;
          end
        end else tmr_q <= tmr_q + 1'b1;
        S_SETTLE: if (tmr_q == TMR_W'(SETTLE_CYCLES - 1)) state_q <= S_IDLE;
                  else tmr_q <= tmr_q + 1'b1;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign cs_n[b]   = !(sh_active && bank_q == BANK_W'(b));
    assign ldac_n[b] = !(state_q == S_LOAD && bank_q == BANK_W'(b));
  end

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '1) |-> !sclk);
  p_ldac_cs_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_n != '1) |-> (cs_n == '1));
  p_mid_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mid_req |=> (busy && cs_n == '1 && ldac_n == '1));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !upd_req && !mid_req) |=> !busy);
endmodule

// File: tb/dac_bank_seq_bench.sv
module dac_bank_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, CPB = 4, DW = 12, FW = 16, HALF = 2, SETTLE = 1000;
  localparam int NCH = NB * CPB;
  localparam logic [DW-1:0] MID = 12'h800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, upd_req = 1'b0, mid_req = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, busy, sclk, sdi;
  logic [NB-1:0] cs_n, ldac_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_bank_seq u_dac_bank_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .upd_req(upd_req), .mid_req(mid_req),
    .busy(busy), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .ldac_n(ldac_n)
  );

  // scoreboard state
  logic [18:0] exp_q [$];          // {device[2:0], frame[15:0]}, driver-owned
  logic [DW-1:0] exp_sh [NCH];
  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  bit abort_ok = 1'b0;
  bit resync_tog = 1'b0;
  int resync_ptr = 0;

  // monitor / DAC models
  logic [FW-1:0] sr [NB];
  int bitcnt [NB];
  int since [NB];
  logic [DW-1:0] dac_in [NB][CPB];
  logic [DW-1:0] dac_out [NB][CPB];
  int rd_ptr = 0;
  bit seen_tog = 1'b0;
  logic prev_sclk = 1'b0, prev_busy = 1'b0;
  logic [NB-1:0] prev_cs = '1, prev_ld = '1;
  int cyc = 0, last_ld = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (resync_tog != seen_tog) begin
        seen_tog = resync_tog;
        rd_ptr = resync_ptr;
        for (int b = 0; b < NB; b++) since[b] = 0;
      end
      for (int b = 0; b < NB; b++) begin
        if (prev_cs[b] && !cs_n[b]) begin
          bitcnt[b] = 0;
          mon_checks++;
          if ($countones(~cs_n) != 1) begin
            mon_errors++;
            $display("FAIL R4 chip selects low: actual %b expected one bit", ~cs_n);
          end
        end
        if (!prev_sclk && sclk && !cs_n[b]) begin
          sr[b] = {sr[b][FW-2:0], sdi};
          bitcnt[b]++;
        end
        if (!prev_cs[b] && cs_n[b]) begin
          if (bitcnt[b] == FW) begin
            mon_checks++;
            if (rd_ptr >= exp_q.size()) begin
              mon_errors++;
              $display("FAIL R8 unexpected frame: actual %h expected none", {3'(b), sr[b]});
            end else begin
              if ({3'(b), sr[b]} != exp_q[rd_ptr]) begin
                mon_errors++;
                $display("FAIL R2/R3 frame: actual %h expected %h", {3'(b), sr[b]}, exp_q[rd_ptr]);
              end
              rd_ptr++;
            end
            dac_in[b][sr[b][15:14]] = sr[b][DW-1:0];
            since[b]++;
          end else if (!abort_ok) begin
            mon_checks++;
            mon_errors++;
            $display("FAIL R4 bits per frame: actual %0d expected %0d", bitcnt[b], FW);
          end
        end
        if (prev_ld[b] && !ldac_n[b]) begin
          mon_checks++;
          if (since[b] != CPB || cs_n != '1) begin
            mon_errors++;
            $display("FAIL R5 load strobe: actual %0d frames cs %b expected %0d frames cs all high",
                     since[b], cs_n, CPB);
          end
          for (int c = 0; c < CPB; c++) dac_out[b][c] = dac_in[b][c];
          since[b] = 0;
        end
        if (!prev_ld[b] && ldac_n[b]) last_ld = cyc;
      end
      if (prev_busy && !busy) begin
        mon_checks++;
        if (cyc - last_ld != SETTLE) begin
          mon_errors++;
          $display("FAIL R6 settle window: actual %0d expected %0d", cyc - last_ld, SETTLE);
        end
      end
      prev_sclk = sclk;
      prev_cs = cs_n;
      prev_ld = ldac_n;
      prev_busy = busy;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_update();
    for (int b = 0; b < NB; b++)
      for (int c = 0; c < CPB; c++)
        exp_q.push_back({3'(b), 2'(c), 2'b00, exp_sh[b*CPB+c]});
  endtask

  task automatic write_ch(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 5'(a); wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    exp_sh[a] = d;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_req = 1'b1;
    @(negedge clk); upd_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic compare_all(input string req);
    for (int n = 0; n < NCH; n++)
      check(dac_out[n/CPB][n%CPB] == exp_sh[n], req, dac_out[n/CPB][n%CPB], exp_sh[n]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end

  initial begin
    for (int n = 0; n < NCH; n++) exp_sh[n] = MID;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b1, "R1 busy in reset", busy, 1);
    check(cs_n == '1, "R4 cs_n in reset", cs_n, 8'hff);
    check(ldac_n == '1, "R5 ldac_n in reset", ldac_n, 8'hff);
    check(sclk == 1'b0, "R4 sclk in reset", sclk, 0);
    check(wr_ready == 1'b0, "R7 wr_ready in reset", wr_ready, 0);
    push_update();
    rst_n = 1'b1;
    wait_idle();
    compare_all("R1 mid-scale after reset");

    // pattern A, R2 R3
    for (int n = 0; n < NCH; n++) write_ch(n, 12'((n * 173 + 5) & 12'hfff));
    push_update();
    pulse_upd();
    check(busy == 1'b1, "R6 busy after update", busy, 1);
    wait_idle();
    compare_all("R3 pattern A");

    // pattern B, last write in the same cycle as the update (R10)
    for (int n = 0; n < NCH - 1; n++) write_ch(n, (n % 2 == 0) ? 12'hfff : 12'h000);
    @(negedge clk);
    check(wr_ready == 1'b1, "R10 ready before joint write", wr_ready, 1);
    wr_valid = 1'b1; wr_addr = 5'(NCH - 1); wr_data = 12'h5a5; upd_req = 1'b1;
    exp_sh[NCH-1] = 12'h5a5;
    push_update();
    @(negedge clk);
    wr_valid = 1'b0; upd_req = 1'b0;
    wait_idle();
    compare_all("R10 pattern B");

    // back-pressure and ignored update (R7, R8)
    push_update();
    pulse_upd();
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 5'd5; wr_data = 12'habc;
    check(wr_ready == 1'b0, "R7 ready low while busy", wr_ready, 0);
    repeat (100) @(negedge clk);
    check(wr_ready == 1'b0, "R7 ready still low", wr_ready, 0);
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    check(dac_out[1][1] == 12'h000, "R7 held write not yet output", dac_out[1][1], 12'h000);
    exp_sh[5] = 12'habc;
    repeat (30) @(negedge clk);
    check(busy == 1'b0, "R8 ignored update", busy, 0);
    check(rd_ptr == exp_q.size(), "R8 no extra frames", rd_ptr, exp_q.size());
    push_update();
    pulse_upd();
    wait_idle();
    compare_all("R7 held write delivered");

    // mid-scale with write and update in the same cycle (R9)
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 5'd3; wr_data = 12'h123; upd_req = 1'b1; mid_req = 1'b1;
    for (int n = 0; n < NCH; n++) exp_sh[n] = MID;
    push_update();
    @(negedge clk);
    wr_valid = 1'b0; upd_req = 1'b0; mid_req = 1'b0;
    wait_idle();
    compare_all("R9 joint mid-scale");

    // mid-scale during a frame (R9)
    for (int n = 0; n < NCH; n++) write_ch(n, 12'(n * 61 + 1));
    push_update();
    pulse_upd();
    while (cs_n[1]) @(negedge clk);
    repeat (10) @(negedge clk);
    abort_ok = 1'b1;
    resync_ptr = exp_q.size();
    resync_tog = ~resync_tog;
    for (int n = 0; n < NCH; n++) exp_sh[n] = MID;
    push_update();
    mid_req = 1'b1;
    @(negedge clk);
    mid_req = 1'b0;
    check(cs_n == '1 && busy, "R9 abort frame", {busy, cs_n}, 9'h1ff);
    wait_idle();
    abort_ok = 1'b0;
    compare_all("R9 abort then mid-scale");

    repeat (5) @(negedge clk);
    check(rd_ptr == exp_q.size(), "R3 all frames seen", rd_ptr, exp_q.size());
    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule